// File: doc/BRIEF.md
# Dual RSC Encoder with Trellis Termination

This block is the coding core of a rate-1/3 parallel concatenated convolutional encoder. Two identical 8-state recursive systematic convolutional encoders run side by side. One consumes a data block in natural order and the other consumes the same block in permuted order. An upstream buffer supplies both orderings as one bit pair per cycle. Each data cycle yields three serial bits: the systematic bit, the parity of the first encoder and the parity of the second encoder.

When the last data bit of a block has been consumed, both encoders are driven back to the all-zero state. The twelve termination bits produced by that process are placed on the three output lanes over four cycles. The block frames its output with a valid flag and one-cycle start and end strobes. It also obeys a downstream ready input that freezes the whole output side.

The source handshake works like this. The block raises a read request. A pair is transferred on a clock edge where both the request and the source's valid flag are high. The first pair of a block carries a first-bit flag and the block length.

Top module: `dual_rsc_term`

## Requirements
- R1: After synchronous reset, out_vld, out_sop and out_eop are low, and src_rd equals dn_rdy.
- R2: A pair transferred on a clock edge appears on the outputs right after that edge. out_sys carries the natural-order bit, out_par1 carries the first encoder's parity for it, out_par2 carries the second encoder's parity for the interleaved bit, and out_vld is high.
- R3: Each encoder has feedback polynomial 1+D^2+D^3 and feed-forward polynomial 1+D+D^3. Its parity bit is w^s1^s3, where w = u^s2^s3 and s1..s3 are the delay stages. Both encoders start every block from the all-zero state.
- R4: The four cycles right after the last data bit are tail cycles. Cycle c (0..3) carries sequence bits 3c, 3c+1 and 3c+2 on out_sys, out_par1 and out_par2. The sequence is x1,z1,x2,z2,x3,z3 of the first encoder followed by the same six bits of the second encoder.
- R5: Tail step i of an encoder outputs x = s2^s3 as its systematic bit and z = s1^s3 as its parity bit, then shifts a zero into s1. The first encoder terminates before the second.
- R6: out_vld is high for exactly K+4 consumed cycles per block of length K. With a source that never pauses and ready held high, back-to-back blocks give an unbroken valid run.
- R7: out_sop is high for one cycle with the first data bit of a block. out_eop is high for one cycle with the last tail cycle. Both are only ever high together with out_vld.
- R8: While dn_rdy is low, every output holds its value, src_rd is low and no internal state advances.
- R9: src_rd is low during tail cycles. A cycle with src_valid low consumes nothing, gives out_vld low, and leaves both encoders untouched.
- R10: Outside a block, a pair whose first-bit flag is low is consumed and discarded with no output. src_len is sampled only with the first pair of a block, and K is 1 to 2^LEN_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Source has a bit pair available |
| src_first | input | 1 | Current pair is the first of a block |
| src_len | input | LEN_W | Block length K, valid with the first pair |
| src_nat | input | 1 | Natural-order data bit |
| src_ilv | input | 1 | Interleaved-order data bit |
| src_rd | output | 1 | Read request to the source |
| dn_rdy | input | 1 | Downstream can take an output beat |
| out_sys | output | 1 | Systematic lane |
| out_par1 | output | 1 | First encoder parity lane |
| out_par2 | output | 1 | Second encoder parity lane |
| out_vld | output | 1 | Output beat valid |
| out_sop | output | 1 | First data bit of a block |
| out_eop | output | 1 | Last tail beat of a block |

## Verification
The bench targets the tail boundary with blocks of length one and two, where the start and the termination sit next to each other. A design that starts the tail one cycle early, or mixes up the lane order, corrupts the twelve tail bits or loses the final parity bit. Back-to-back blocks expose encoder state carried over from the previous block, and a one-cycle gap between blocks where valid drops. Random downstream stalls and source pauses in the middle of the tail show any state that advances while frozen, or a pair read while the encoders are terminating.

// File: rtl/rscterm_pkg.sv
package rscterm_pkg;
  localparam int MEM    = 3;
  localparam int NENC   = 2;
  localparam int TAILB  = 2 * MEM;
  localparam int LANES  = 3;
  localparam int TCYC   = (NENC * TAILB) / LANES;
  localparam int TSEL_W = $clog2(TCYC);

  typedef struct packed {
    logic sys;
    logic p1;
    logic p2;
    logic vld;
    logic sop;
    logic eop;
  } beat_t;

  // Termination sequence {.., z1, x1} from state st (st[0] is the first delay).
  function automatic logic [TAILB-1:0] term_bits(input logic [MEM-1:0] st_in,
                                                 input logic [MEM-1:0] fb_taps,
                                                 input logic [MEM-1:0] ff_taps);
    logic [MEM-1:0] st;
    logic [TAILB-1:0] seq;
    st  = st_in;
    seq = '0;
    for (int i = 0; i < MEM; i++) begin
      seq[2*i]   = ^(st & fb_taps);
      seq[2*i+1] = ^(st & ff_taps);
      st = {st[MEM-2:0], 1'b0};
    end
    return seq;
  endfunction
endpackage

// File: rtl/rsc_enc.sv
module rsc_enc
  import rscterm_pkg::*;
#(
  parameter logic [MEM:0] G_FB = 4'b1101,
  parameter logic [MEM:0] G_FF = 4'b1011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic             u,
  output logic             par,
  output logic [TAILB-1:0] tail
);
  logic [MEM-1:0] st_q;
  logic [MEM-1:0] st_eff;
  logic           fb;
  logic           w;

  always_comb begin
    st_eff = clr ? '0 : st_q;
    fb     = ^(st_eff & G_FB[MEM:1]);
    w      = u ^ fb;
    par    = (G_FF[0] & w) ^ (^(st_eff & G_FF[MEM:1]));
    tail   = term_bits(st_q, G_FB[MEM:1], G_FF[MEM:1]);
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else if (step) st_q <= {st_eff[MEM-2:0], w};
  end

  // R3: a block's first step starts from zero, so only the newest stage can be set
  p_start_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (step && clr) |=> (st_q[MEM-1:1] == '0));
endmodule

// File: rtl/frame_ctl.sv
module frame_ctl
  import rscterm_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              src_valid,
  input  logic              src_first,
  input  logic [LEN_W-1:0]  src_len,
  output logic              src_rd,
  output logic              take,
  output logic              start,
  output logic              in_tail,
  output logic [TSEL_W-1:0] tsel
);
  logic             busy_q;
  logic             tail_q;
  logic [LEN_W-1:0] rem_q;
  logic [TSEL_W-1:0] tcnt_q;
  logic             last;

  always_comb begin
    src_rd  = adv & ~tail_q;
    take    = src_rd & src_valid & (busy_q | src_first);
    start   = take & ~busy_q;
    last    = take & (busy_q ? (rem_q == LEN_W'(1)) : (src_len == LEN_W'(1)));
    in_tail = tail_q;
    tsel    = tcnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tail_q <= 1'b0;
      rem_q  <= '0;
      tcnt_q <= '0;
    end else if (adv) begin
      if (take) begin
        if (last) begin
          busy_q <= 1'b0;
          tail_q <= 1'b1;
          tcnt_q <= '0;
        end else begin
          busy_q <= 1'b1;
          rem_q  <= (busy_q ? rem_q : src_len) - LEN_W'(1);
        end
      end
      if (tail_q) begin
        tcnt_q <= tcnt_q + TSEL_W'(1);
        if (tcnt_q == TSEL_W'(TCYC - 1)) tail_q <= 1'b0;
      end
    end
  end

  // R4: the last data bit is followed immediately by tail cycles
  p_enter_tail_r4: assert property (@(posedge clk) disable iff (rst)
    last |=> (in_tail && tsel == '0));
  // R4: the tail ends after its final cycle
  p_exit_tail_r4: assert property (@(posedge clk) disable iff (rst)
    (in_tail && adv && tsel == TSEL_W'(TCYC - 1)) |=> !in_tail);
endmodule

// File: rtl/dual_rsc_term.sv
module dual_rsc_term
  import rscterm_pkg::*;
#(
  parameter int           LEN_W = 13,
  parameter logic [MEM:0] G_FB  = 4'b1101,
  parameter logic [MEM:0] G_FF  = 4'b1011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_valid,
  input  logic             src_first,
  input  logic [LEN_W-1:0] src_len,
  input  logic             src_nat,
  input  logic             src_ilv,
  output logic             src_rd,
  input  logic             dn_rdy,
  output logic             out_sys,
  output logic             out_par1,
  output logic             out_par2,
  output logic             out_vld,
  output logic             out_sop,
  output logic             out_eop
);
  logic                    take;
  logic                    start;
  logic                    in_tail;
  logic [TSEL_W-1:0]       tsel;
  logic [NENC-1:0]         bit_in;
  logic [NENC-1:0]         par;
  logic [NENC*TAILB-1:0]   tail_all;
  logic [LANES-1:0]        lane;
  beat_t                   beat_q;

  frame_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rst(rst), .adv(dn_rdy),
    .src_valid(src_valid), .src_first(src_first), .src_len(src_len),
    .src_rd(src_rd), .take(take), .start(start),
    .in_tail(in_tail), .tsel(tsel)
  );

  assign bit_in = {src_ilv, src_nat};

  for (genvar e = 0; e < NENC; e++) begin : g_enc
    rsc_enc #(.G_FB(G_FB), .G_FF(G_FF)) u_enc (
      .clk(clk), .rst(rst), .clr(start), .step(take),
      .u(bit_in[e]), .par(par[e]),
      .tail(tail_all[e*TAILB +: TAILB])
    );
  end

  always_comb begin
    lane = tail_all[int'(tsel) * LANES +: LANES];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else if (dn_rdy) begin
      if (take) begin
        beat_q.sys <= src_nat;
        beat_q.p1  <= par[0];
        beat_q.p2  <= par[1];
        beat_q.vld <= 1'b1;
        beat_q.sop <= start;
        beat_q.eop <= 1'b0;
      end else if (in_tail) begin
        beat_q.sys <= lane[0];
        beat_q.p1  <= lane[1];
        beat_q.p2  <= lane[2];
        beat_q.vld <= 1'b1;
        beat_q.sop <= 1'b0;
        beat_q.eop <= (tsel == TSEL_W'(TCYC - 1));
      end else begin
        beat_q <= '0;
      end
    end
  end

  assign out_sys  = beat_q.sys;
  assign out_par1 = beat_q.p1;
  assign out_par2 = beat_q.p2;
  assign out_vld  = beat_q.vld;
  assign out_sop  = beat_q.sop;
  assign out_eop  = beat_q.eop;

  // R7: strobes only accompany valid beats
  p_sop_vld_r7: assert property (@(posedge clk) disable iff (rst) out_sop |-> out_vld);
  p_eop_vld_r7: assert property (@(posedge clk) disable iff (rst) out_eop |-> out_vld);
  // R7: end strobe lasts a single consumed beat
  p_eop_single_r7: assert property (@(posedge clk) disable iff (rst)
    (out_eop && dn_rdy) |=> !out_eop);
  // R8: a stalled cycle leaves the output beat unchanged
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !dn_rdy |=> $stable(beat_q));
endmodule

// File: tb/dual_rsc_term_bench.sv
`timescale 1ns/1ps
module dual_rsc_term_bench;
  localparam int LEN_W = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_valid = 1'b0, src_first = 1'b0, src_nat = 1'b0, src_ilv = 1'b0;
  logic [LEN_W-1:0] src_len = '0;
  logic dn_rdy = 1'b1;
  logic src_rd, out_sys, out_par1, out_par2, out_vld, out_sop, out_eop;

  always #4 clk = ~clk;

  dual_rsc_term #(.LEN_W(LEN_W)) u_dual_rsc_term (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_first(src_first),
    .src_len(src_len), .src_nat(src_nat), .src_ilv(src_ilv), .src_rd(src_rd),
    .dn_rdy(dn_rdy), .out_sys(out_sys), .out_par1(out_par1), .out_par2(out_par2),
    .out_vld(out_vld), .out_sop(out_sop), .out_eop(out_eop)
  );

  typedef struct { bit sys, p1, p2, sop, eop; int tidx; } exp_t;
  exp_t expq[$];
  int   sop_t[$];
  int   eop_t[$];
  int   vectors = 0, fails = 0, cyc = 0, vld_cnt = 0;
  int   stall_mode = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // reference encoder step from the stated polynomials
  function automatic bit ref_step(inout bit [2:0] s, input bit u);
    bit w;
    w = u ^ s[1] ^ s[2];
    ref_step = w ^ s[0] ^ s[2];
    s = {s[1:0], w};
  endfunction

  function automatic void ref_tail(input bit [2:0] s0, output bit [5:0] seq);
    bit [2:0] s;
    s = s0;
    for (int i = 0; i < 3; i++) begin
      seq[2*i]   = s[1] ^ s[2];
      seq[2*i+1] = s[0] ^ s[2];
      s = {s[1:0], 1'b0};
    end
  endfunction

  task automatic send_block(input int k, input bit gaps);
    bit nat[$];
    bit ilv[$];
    bit [2:0] s1, s2;
    bit [5:0] t1, t2;
    bit [11:0] tall;
    exp_t e;
    s1 = '0; s2 = '0;
    for (int i = 0; i < k; i++) begin
      nat.push_back(1'($urandom_range(0, 1)));
      ilv.push_back(1'($urandom_range(0, 1)));
      e.sys = nat[i];
      e.p1  = ref_step(s1, nat[i]);
      e.p2  = ref_step(s2, ilv[i]);
      e.sop = (i == 0); e.eop = 0; e.tidx = -1;
      expq.push_back(e);
    end
    ref_tail(s1, t1);
    ref_tail(s2, t2);
    tall = {t2, t1};
    for (int c = 0; c < 4; c++) begin
      e.sys = tall[3*c]; e.p1 = tall[3*c+1]; e.p2 = tall[3*c+2];
      e.sop = 0; e.eop = (c == 3); e.tidx = c;
      expq.push_back(e);
    end
    for (int i = 0; i < k; i++) begin
      if (gaps && (i % 3 == 1)) begin   // R9: pause the source mid-block
        src_valid = 0;
        @(posedge clk); #1;
      end
      src_valid = 1;
      src_nat   = nat[i];
      src_ilv   = ilv[i];
      src_first = (i == 0);
      src_len   = (i == 0) ? LEN_W'(k) : LEN_W'($urandom);  // R10: length ignored after first
      @(negedge clk);
      while (!src_rd) @(negedge clk);
      @(posedge clk); #1;
    end
    src_valid = 0;
    src_first = 0;
  endtask

  // downstream ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      dn_rdy = (stall_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
    end
  end

  always @(posedge clk) cyc++;

  // monitor / scoreboard
  bit stall_prev = 0;
  bit [5:0] snap;
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (stall_prev)
        check({out_sys, out_par1, out_par2, out_vld, out_sop, out_eop} == snap,
              "R8 outputs held during stall",
              {out_sys, out_par1, out_par2, out_vld, out_sop, out_eop}, snap);
      if (!dn_rdy)
        check(src_rd == 1'b0, "R8 src_rd low while stalled", src_rd, 0);
      if (dn_rdy && out_vld) begin
        vld_cnt++;
        if (expq.size() == 0) begin
          check(0, "R10 unexpected valid output", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check({out_sys, out_par1, out_par2} == {e.sys, e.p1, e.p2},
                (e.tidx < 0) ? "R2 R3 data lanes" : "R4 R5 tail lanes",
                {out_sys, out_par1, out_par2}, {e.sys, e.p1, e.p2});
          check({out_sop, out_eop} == {e.sop, e.eop}, "R7 strobes",
                {out_sop, out_eop}, {e.sop, e.eop});
          if (e.tidx >= 0 && e.tidx <= 2)
            check(src_rd == 1'b0, "R9 no read during tail", src_rd, 0);
          if (out_sop) sop_t.push_back(cyc);
          if (out_eop) eop_t.push_back(cyc);
        end
      end
      stall_prev = !dn_rdy;
      snap = {out_sys, out_par1, out_par2, out_vld, out_sop, out_eop};
    end
  end

  task automatic drain();
    while (expq.size() != 0) @(posedge clk);
    repeat (6) @(posedge clk);
    #1;
  endtask

  // watchdog
  initial begin
    while (cyc < 150000 && !done) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n, v0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    check(out_vld == 0, "R1 out_vld after reset", out_vld, 0);
    check(out_sop == 0 && out_eop == 0, "R1 strobes after reset", {out_sop, out_eop}, 0);
    check(src_rd == dn_rdy, "R1 src_rd follows dn_rdy", src_rd, dn_rdy);
    @(posedge clk); #1;

    // R10: non-first pairs outside a block are dropped
    v0 = vld_cnt;
    src_valid = 1; src_first = 0; src_len = 7;
    repeat (5) begin src_nat = 1'($urandom_range(0,1)); src_ilv = 1; @(posedge clk); #1; end
    src_valid = 0;
    repeat (6) @(posedge clk); #1;
    check(vld_cnt == v0, "R10 dropped pairs give no output", vld_cnt - v0, 0);

    // R2 R3 R6: single block, then span check
    n = sop_t.size();
    send_block(40, 0);
    drain();
    check(eop_t[n] - sop_t[n] + 1 == 44, "R6 valid span K+4", eop_t[n] - sop_t[n] + 1, 44);

    // R6 R3: back-to-back blocks, unbroken valid
    n = sop_t.size();
    send_block(40, 0);
    send_block(48, 0);
    drain();
    check(eop_t[n+1] - sop_t[n] + 1 == 96, "R6 back-to-back span", eop_t[n+1] - sop_t[n] + 1, 96);

    // R4 R5: shortest blocks
    send_block(1, 0);
    send_block(2, 0);
    send_block(3, 0);
    drain();

    // R9: source pauses
    send_block(64, 1);
    drain();

    // R8: random downstream stalls
    stall_mode = 1;
    send_block(100, 0);
    send_block(40, 1);
    send_block(1, 0);
    drain();
    stall_mode = 0;
    repeat (4) @(posedge clk); #1;

    check(expq.size() == 0, "R6 all expected beats produced", expq.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule